// File: doc/BRIEF.md
# Banked Register and RAM Access Decoder

This block sits between a synchronous host port and the storage of a battery-backed clock. It decodes a 128-location byte space. The lowest locations always reach an external clock-register file. The meaning of the rest depends on a bank flag.

With the flag clear, the upper locations are general-purpose bytes held inside the block. With the flag set, the same upper locations become an indirect window into a larger extended RAM, also held inside the block. In that window, two locations form a pointer and a third moves data. The pointer steps forward after every data access, so software can stream through the array.

The bank flag is taken from one bit of a clock register. The block watches host writes to that register and keeps its own copy of the bit; the write still goes on to the clock file. While the clock logic reports an update in progress, the clock registers are shielded from the host. The general-purpose bytes and the extended RAM stay fully usable during that time.

Top module: `banked_regspace`

## Requirements
- R1: A host write to locations 0 to 13 pulses `rtc_we` in the same cycle, with `rtc_addr` equal to `addr[3:0]` and `rtc_wdata` equal to `wdata`. This holds in both banks. A host read there returns `rtc_rdata` on `rdata` one cycle later.
- R2: A host write to location 0x0A sets the bank flag to bit 4 of `wdata`, even while an update is in progress. Reset clears the flag, which selects bank 0.
- R3: In bank 0, locations 14 to 127 are 114 independent read/write bytes. A read returns the stored byte on `rdata` one cycle after the read strobe.
- R4: In bank 1, a write to location 0x50 loads the low 8 bits of the extended pointer. A write to location 0x51 loads the remaining `XADDR_W-8` high bits from the low bits of `wdata`. Reads of these locations return the pointer parts, zero-extended.
- R5: In bank 1, a write to location 0x53 stores `wdata` at the pointer. A read of location 0x53 returns the byte at the pointer. Each such access then adds one to the pointer.
- R6: The pointer wraps from `2**XADDR_W-1` to 0. Reset clears the pointer to 0.
- R7: In bank 1, upper locations other than 0x50, 0x51 and 0x53 read as 0, and writes to them are ignored. Bank-0 bytes keep their contents while bank 1 is selected.
- R8: While `upd_busy` is high, reads of locations 0 to 13 return 0 and writes to them do not pulse `rtc_we`. Bank-0 bytes and the extended RAM keep working normally.
- R9: `rdata` is 0 after reset and changes only after a read that has no write alongside it. When `rd` and `wr` are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 7 | Host location |
| wdata | input | 8 | Host write data |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| rdata | output | 8 | Registered host read data |
| upd_busy | input | 1 | Clock update in progress |
| rtc_addr | output | 4 | Clock-register index |
| rtc_wdata | output | 8 | Clock-register write data |
| rtc_we | output | 1 | Clock-register write enable |
| rtc_rdata | input | 8 | Clock-register read data, combinational from `rtc_addr` |

## Verification
The bench builds the block with `XADDR_W` = 9, which gives a 512-byte extended RAM. With this size the bench can fill every byte by streaming through the data location. It can also run the pointer across its wrap point several times within a few thousand cycles. The other parameters keep their defaults, so the 14 clock locations, the bank bit and the window locations are exactly as the requirements state. Randomly chosen upper locations, busy periods and bank switches reach the bank-1 locations that read as zero and the interplay between the shield and the general-purpose bytes.

// File: rtl/banked_regspace.sv
module banked_regspace #(
  parameter int XADDR_W = 12,
  parameter int CLK_REGS = 14,
  parameter logic [6:0] BANK_LOC = 7'h0A,
  parameter int BANK_BIT = 4,
  parameter logic [6:0] XLO_LOC = 7'h50,
  parameter logic [6:0] XHI_LOC = 7'h51,
  parameter logic [6:0] XDAT_LOC = 7'h53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] addr,
  input  logic [7:0] wdata,
  input  logic       rd,
  input  logic       wr,
  output logic [7:0] rdata,
  input  logic       upd_busy,
  output logic [3:0] rtc_addr,
  output logic [7:0] rtc_wdata,
  output logic       rtc_we,
  input  logic [7:0] rtc_rdata
);
  localparam int XDEPTH = 1 << XADDR_W;
  localparam int HI_W = XADDR_W - 8;

  logic bank;
  logic [XADDR_W-1:0] xaddr;
  logic [7:0] uram [CLK_REGS:127];
  logic [7:0] xram [XDEPTH];
  logic [7:0] rd_val;

  wire is_clk = addr < 7'(CLK_REGS);
  wire in_x   = bank && !is_clk;
  wire hit_lo = in_x && addr == XLO_LOC;
  wire hit_hi = in_x && addr == XHI_LOC;
  wire hit_dt = in_x && addr == XDAT_LOC;
  wire rd_en  = rd && !wr;

  assign rtc_addr  = addr[3:0];
  assign rtc_wdata = wdata;
  assign rtc_we    = wr && is_clk && !upd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank  <= 1'b0;
      xaddr <= '0;
    end else begin
      if (wr && addr == BANK_LOC) bank <= wdata[BANK_BIT];
      if (wr && hit_lo) xaddr[7:0] <= wdata;
      else if (wr && hit_hi) xaddr[XADDR_W-1:8] <= wdata[HI_W-1:0];
      else if ((wr || rd_en) && hit_dt) xaddr <= xaddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !bank && !is_clk) uram[addr] <= wdata;
    if (wr && hit_dt) xram[xaddr] <= wdata;
  end

  always_comb begin
    if (is_clk)      rd_val = upd_busy ? 8'h00 : rtc_rdata;
    else if (!bank)  rd_val = uram[addr];
    else if (hit_lo) rd_val = xaddr[7:0];
    else if (hit_hi) rd_val = 8'(xaddr >> 8);
    else if (hit_dt) rd_val = xram[xaddr];
    else             rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

module banked_regspace_chk #(
  parameter int XADDR_W = 12,
  parameter int CLK_REGS = 14,
  parameter logic [6:0] BANK_LOC = 7'h0A,
  parameter logic [6:0] XDAT_LOC = 7'h53
) (
  input logic clk,
  input logic rst_n,
  input logic [6:0] addr,
  input logic rd,
  input logic wr,
  input logic upd_busy,
  input logic rtc_we,
  input logic [7:0] rdata,
  input logic bank,
  input logic [XADDR_W-1:0] xaddr
);
  AST_RTC_WE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_we |-> (wr && addr < 7'(CLK_REGS))); // R1
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == BANK_LOC) |=> $stable(bank)); // R2
  AST_XADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bank && addr == XDAT_LOC && (wr || rd)) |=> xaddr == $past(xaddr) + 1'b1); // R5
  AST_BUSY_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_busy |-> !rtc_we); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && !wr) |=> $stable(rdata)); // R9
endmodule

bind banked_regspace banked_regspace_chk #(
  .XADDR_W(XADDR_W), .CLK_REGS(CLK_REGS), .BANK_LOC(BANK_LOC), .XDAT_LOC(XDAT_LOC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .upd_busy(upd_busy),
  .rtc_we(rtc_we), .rdata(rdata), .bank(bank), .xaddr(xaddr)
);

// File: tb/tb_banked_regspace.sv
module tb_banked_regspace;
  localparam int XW = 9;
  localparam int XD = 1 << XW;

  logic clk = 0;
  logic rst_n = 0;
  logic [6:0] addr = 0;
  logic [7:0] wdata = 0;
  logic rd = 0, wr = 0, upd_busy = 0;
  logic [7:0] rdata, rtc_wdata, rtc_rdata;
  logic [3:0] rtc_addr;
  logic rtc_we;

  always #5 clk = ~clk;

  banked_regspace #(.XADDR_W(XW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .rdata(rdata), .upd_busy(upd_busy), .rtc_addr(rtc_addr), .rtc_wdata(rtc_wdata),
    .rtc_we(rtc_we), .rtc_rdata(rtc_rdata)
  );

  logic [7:0] rtc_file [16];
  assign rtc_rdata = rtc_file[rtc_addr];
  always @(posedge clk) if (rtc_we) rtc_file[rtc_addr] <= rtc_wdata;

  logic [7:0] m_rtc [14];
  logic [7:0] m_uram [128];
  logic [7:0] m_x [XD];
  logic m_bank = 0;
  logic [XW-1:0] m_xa = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    if (a < 14) return upd_busy ? 8'h00 : m_rtc[a];
    if (!m_bank) return m_uram[a];
    if (a == 7'h50) return m_xa[7:0];
    if (a == 7'h51) return {7'b0, m_xa[8]};
    if (a == 7'h53) return m_x[m_xa];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [6:0] a, input logic [7:0] d, input string tag);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    #1;
    check({tag, " rtc_we"}, {7'b0, rtc_we}, {7'b0, (a < 14) && !upd_busy});
    if (rtc_we) check({tag, " rtc_addr/wdata"}, rtc_wdata ^ {4'b0, rtc_addr}, d ^ {4'b0, a[3:0]});
    @(negedge clk); wr = 0;
    if (a == 7'h0A) m_bank = d[4];
    if (a < 14) begin
      if (!upd_busy) m_rtc[a] = d;
    end else if (!m_bank) m_uram[a] = d;
    else if (a == 7'h50) m_xa[7:0] = d;
    else if (a == 7'h51) m_xa[8] = d[0];
    else if (a == 7'h53) begin m_x[m_xa] = d; m_xa = m_xa + 1'b1; end
  endtask

  task automatic do_rd(input logic [6:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk); addr = a; rd = 1;
    e = exp_read(a);
    @(negedge clk); rd = 0;
    check(tag, rdata, e);
    if (m_bank && a == 7'h53) m_xa = m_xa + 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) rtc_file[i] = 0;
    for (int i = 0; i < 14; i++) m_rtc[i] = 0;
    repeat (3) @(negedge clk);
    check("R9 reset rdata", rdata, 8'h00);
    rst_n = 1;

    for (int i = 0; i < 14; i++) do_wr(7'(i), (i == 10) ? 8'h05 : 8'(i * 3 + 1), "R1");
    for (int i = 0; i < 14; i++) do_rd(7'(i), "R1 clock read");
    for (int i = 14; i < 128; i++) do_wr(7'(i), 8'($urandom), "R3");
    for (int i = 14; i < 128; i++) do_rd(7'(i), "R3 user byte");

    do_rd(7'h50, "R7 bank0 0x50 is user RAM");
    do_wr(7'h0A, 8'h10, "R2");
    do_rd(7'h50, "R6 reset pointer low");
    do_rd(7'h51, "R6 reset pointer high");
    for (int i = 0; i < XD; i++) do_wr(7'h53, 8'($urandom), "R5");
    do_rd(7'h50, "R6 wrapped pointer low");
    do_rd(7'h51, "R6 wrapped pointer high");
    for (int i = 0; i < 20; i++) do_rd(7'h53, "R5 stream read");
    do_wr(7'h50, 8'hFF, "R4"); do_wr(7'h51, 8'h03, "R4");
    do_rd(7'h50, "R4 pointer low"); do_rd(7'h51, "R4 pointer high masked");
    do_rd(7'h53, "R6 last byte"); do_rd(7'h53, "R6 first byte after wrap");
    do_rd(7'h51, "R6 high after wrap");

    do_rd(7'h20, "R7 unused reads zero");
    do_wr(7'h20, 8'hA5, "R7");
    do_rd(7'h20, "R7 write ignored");
    do_rd(7'h05, "R1 clock in bank1");
    do_wr(7'h0A, 8'h00, "R2");
    do_rd(7'h20, "R7 user byte preserved");

    upd_busy = 1;
    do_rd(7'h03, "R8 busy clock read");
    do_wr(7'h03, 8'h77, "R8");
    do_wr(7'h30, 8'h5A, "R8");
    do_rd(7'h30, "R8 user byte during busy");
    upd_busy = 0;
    do_rd(7'h03, "R8 clock unchanged");

    prev = rdata;
    @(negedge clk); addr = 7'h31; wdata = 8'hC3; rd = 1; wr = 1;
    @(negedge clk); rd = 0; wr = 0; m_uram[7'h31] = 8'hC3;
    check("R9 rd+wr holds rdata", rdata, prev);
    do_rd(7'h31, "R9 rd+wr write landed");
    do_rd(7'h00, "R9 read");
    prev = rdata;
    repeat (3) @(negedge clk);
    check("R9 idle hold", rdata, prev);

    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a;
      int r = $urandom % 10;
      if (r == 0) a = 7'h0A;
      else if (r < 4) a = 7'h50 + 7'($urandom % 4);
      else a = 7'($urandom);
      upd_busy = ($urandom % 4) == 0;
      if ($urandom % 2) do_wr(a, 8'($urandom), "R3/R5 random");
      else do_rd(a, "R3/R5/R7/R8 random read");
    end
    upd_busy = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule